// File: doc/BRIEF.md
# I2C 16-bit Register Slave

This block is the control port of an audio delay core. It sits on a two-wire I2C bus as a slave and holds nine 16-bit registers. One is a control/status word and eight hold per-channel delay lengths in samples. SCL and SDA are sampled with the core clock. The block drives SDA low for acknowledges and read data. After it has acknowledged its device address, it holds SCL low for a fixed number of core cycles.

A transfer names a register with one subaddress byte. A write then carries the high data byte and the low data byte. A read uses a repeated start and the read address, and the slave returns the high byte first. A pin chooses which of two address pairs the slave answers to. The register contents go straight to the core as wires. The core returns one status bit that reports its current sample width, and that bit appears in the control word on readback.

Top module: `i2c_reg_slave`

## Requirements
- R1: With `addr_pick` low the slave acknowledges only bus bytes 0x82 (write) and 0x83 (read). With it high, it acknowledges only 0x84 and 0x85. Any other address byte gets no acknowledge, and no register changes.
- R2: Subaddress 0x00 names the control word. Subaddress 0x0n (n = 1..8) names the delay of channel n, which drives `ch_delay[16*n-1 -: 16]`.
- R3: A write is start, write address, subaddress, high byte, low byte, stop. The slave acknowledges all four bytes, and the addressed register then holds {high, low}.
- R4: A read is start, write address, subaddress, repeated start, read address, then two bytes. Both bytes go out MSB first and high byte first. The low byte is sent only if the master acknowledged the high byte, and after the master's NAK the slave leaves SDA released.
- R5: After acknowledging a matching device address, the slave holds SCL low for exactly HOLD_CYC core cycles, then releases it.
- R6: After reset, every register is 0x0000, so `drv_en` = 0, `ch_pass` = 0 (all channels muted), `strobe_pol` = 0, `drv_strong` = 0 and `ch_delay` = 0. Both bus drivers are released.
- R7: A read of the control word returns `wide_stat` in bit 14 and zero in bits 15 and 13..11. Writing bits 15..11 has no effect.
- R8: Control bits drive the outputs as follows. Bit 10 drives `strobe_pol`. Bit 2+k drives `ch_pass[k]` (1 = channel k+1 passes, 0 = muted). Bit 1 drives `drv_en`, and bit 0 drives `drv_strong`.
- R9: After a subaddress above 0x08, the slave does not acknowledge write data bytes, and it does not acknowledge a following read address. In both cases no register changes.
- R10: A register is written only after both data bytes have been acknowledged. A stop after the high byte alone leaves every register unchanged.
- R11: The slave changes its SDA drive only while SCL is low. A stop condition releases both SDA and SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, SCL/SDA sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pick | input | 1 | Chooses the device address pair |
| wide_stat | input | 1 | Core status: 1 = 32-bit samples, 0 = 18-bit |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 holds SCL low (stretch) |
| strobe_pol | output | 1 | Frame strobe polarity select |
| ch_pass | output | 8 | Per-channel pass (1) or mute (0) |
| drv_en | output | 1 | Audio output driver enable |
| drv_strong | output | 1 | Audio output drive strength |
| ch_delay | output | NUM_CH*16 | Delay lengths, channel 1 in the low 16 bits |

## Verification
The hardest case to reach from the ports is a write that the master stops after the high byte. That byte has been acknowledged, so the slave is waiting for the low byte. The bench builds this from its bit-level master tasks and then reads every register back to show that nothing moved. An invalid subaddress followed by a repeated start is reached the same way and checked through the NAK on the read address. The stretch is measured at `scl_oe` while the master tries to raise SCL. Random writes over both address pairs and all nine subaddresses, each followed by readback, cover the register mapping.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int MUTE_W  = 8;
    localparam int CTL_W   = 11;
    localparam int WIDE_BIT = 14;

    localparam logic [6:0] DEV_ID_LO = 7'h41;
    localparam logic [6:0] DEV_ID_HI = 7'h42;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_HOLD,
        S_TX,
        S_MACK
    } link_st_t;

    typedef enum logic [1:0] {
        P_DEV,
        P_SUB,
        P_DHI,
        P_DLO
    } phase_t;

    typedef struct packed {
        logic              pol;
        logic [MUTE_W-1:0] pass;
        logic              drv_en;
        logic              drv_strong;
    } ctrl_t;

    function automatic logic [6:0] dev_id(input logic pick);
        return pick ? DEV_ID_HI : DEV_ID_LO;
    endfunction

    function automatic logic sub_ok(input logic [BYTE_W-1:0] s, input int unsigned n);
        return 32'(s) <= n;
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s    = scl_p[STAGES-1];
    assign sda_s    = sda_p[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_reg_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic                    wide_stat,
    output logic [REG_W-1:0]        rd_data,
    output ctrl_t                   ctrl_o,
    output logic [NUM_CH*REG_W-1:0] dly_o
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_idx == '0) begin
            ctrl_q <= ctrl_t'(wr_data[CTL_W-1:0]);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [REG_W-1:0] len_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                len_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(c + 1)) begin
                len_q <= wr_data;
            end
        end
        assign dly_o[c*REG_W +: REG_W] = len_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) begin
            rd_data = {1'b0, wide_stat, 3'b000, ctrl_q};
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_idx == IDX_W'(i + 1)) begin
                rd_data = dly_o[i*REG_W +: REG_W];
            end
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_reg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int HOLD_CYC = 12,
    localparam int IDX_W  = $clog2(NUM_CH + 1),
    localparam int HOLD_W = $clog2(HOLD_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             addr_pick,
    input  logic [REG_W-1:0] rd_data,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data,
    output logic [IDX_W-1:0] rd_idx
);
    link_st_t          st;
    phase_t            ph;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sh, sub_q, hi_q, tx_sh, tx_lo;
    logic              is_rd, tx_second, mack;
    logic [HOLD_W-1:0] hold_cnt;
    logic              ack_ok;

    // decide the acknowledge for the byte just received
    always_comb begin
        unique case (ph)
            P_DEV:   ack_ok = (sh[7:1] == dev_id(addr_pick)) &&
                              (!sh[0] || sub_ok(sub_q, NUM_CH));
            P_SUB:   ack_ok = 1'b1;
            P_DHI:   ack_ok = sub_ok(sub_q, NUM_CH);
            default: ack_ok = 1'b1;
        endcase
    end

    assign rd_idx = sub_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ph        <= P_DEV;
            bit_cnt   <= '0;
            sh        <= '0;
            sub_q     <= '0;
            hi_q      <= '0;
            tx_sh     <= '0;
            tx_lo     <= '0;
            is_rd     <= 1'b0;
            tx_second <= 1'b0;
            mack      <= 1'b0;
            hold_cnt  <= '0;
            sda_oe    <= 1'b0;
            scl_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st      <= S_RX;
                ph      <= P_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                scl_oe  <= 1'b0;
            end else if (stop_ev) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else begin
                unique case (st)
                    S_RX: begin
                        if (scl_rise) begin
                            sh      <= {sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (ack_ok) begin
                                sda_oe <= 1'b1;
                                st     <= S_ACK;
                                if (ph == P_DEV) is_rd <= sh[0];
                                if (ph == P_SUB) sub_q <= sh;
                                if (ph == P_DHI) hi_q  <= sh;
                            end else begin
                                st <= S_IDLE;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            unique case (ph)
                                P_DEV: begin
                                    st        <= S_HOLD;
                                    scl_oe    <= 1'b1;
                                    hold_cnt  <= HOLD_W'(HOLD_CYC);
                                    tx_second <= 1'b0;
                                    if (is_rd) begin
                                        tx_sh  <= rd_data[15:8];
                                        tx_lo  <= rd_data[7:0];
                                        sda_oe <= ~rd_data[15];
                                    end else begin
                                        sda_oe <= 1'b0;
                                    end
                                end
                                P_SUB: begin
                                    sda_oe <= 1'b0;
                                    ph     <= P_DHI;
                                    st     <= S_RX;
                                end
                                P_DHI: begin
                                    sda_oe <= 1'b0;
                                    ph     <= P_DLO;
                                    st     <= S_RX;
                                end
                                default: begin
                                    sda_oe  <= 1'b0;
                                    wr_en   <= 1'b1;
                                    wr_idx  <= sub_q[IDX_W-1:0];
                                    wr_data <= {hi_q, sh};
                                    st      <= S_IDLE;
                                end
                            endcase
                        end
                    end
                    S_HOLD: begin
                        if (hold_cnt <= HOLD_W'(1)) begin
                            scl_oe <= 1'b0;
                            if (is_rd) begin
                                st <= S_TX;
                            end else begin
                                st <= S_RX;
                                ph <= P_SUB;
                            end
                        end else begin
                            hold_cnt <= hold_cnt - HOLD_W'(1);
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                st      <= S_MACK;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack && !tx_second) begin
                                tx_second <= 1'b1;
                                tx_sh     <= tx_lo;
                                sda_oe    <= ~tx_lo[7];
                                bit_cnt   <= '0;
                                st        <= S_TX;
                            end else begin
                                st <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int HOLD_CYC    = 12,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(NUM_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_pick,
    input  logic                    wide_stat,
    output logic                    sda_oe,
    output logic                    scl_oe,
    output logic                    strobe_pol,
    output logic [MUTE_W-1:0]       ch_pass,
    output logic                    drv_en,
    output logic                    drv_strong,
    output logic [NUM_CH*REG_W-1:0] ch_delay
);
    logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [REG_W-1:0] wr_data, rd_data;
    ctrl_t            ctrl;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_link_fsm #(.NUM_CH(NUM_CH), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .addr_pick(addr_pick), .rd_data(rd_data), .sda_oe(sda_oe),
        .scl_oe(scl_oe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx)
    );

    i2c_reg_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .wide_stat(wide_stat),
        .rd_data(rd_data), .ctrl_o(ctrl), .dly_o(ch_delay)
    );

    assign strobe_pol = ctrl.pol;
    assign ch_pass    = ctrl.pass;
    assign drv_en     = ctrl.drv_en;
    assign drv_strong = ctrl.drv_strong;

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter int NUM_CH   = 8,
    parameter int HOLD_CYC = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_i,
    input logic                 sda_oe,
    input logic                 scl_oe,
    input logic                 stop_ev,
    input logic [10:0]          ctrl_word,
    input logic [NUM_CH*16-1:0] ch_delay
);
    localparam int RUN_W = $clog2(HOLD_CYC + 2);
    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !scl_oe) begin
            run_cnt <= '0;
        end else if (run_cnt != '1) begin
            run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    a_r6_reset_values: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_word == '0 && ch_delay == '0 && !sda_oe && !scl_oe));

    a_r5_hold_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(run_cnt) <= HOLD_CYC);

    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (!sda_oe && !scl_oe));

    a_r10_regs_move_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ch_delay) || !$stable(ctrl_word)) |-> !scl_i);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_CH(NUM_CH), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .stop_ev(stop_ev), .ctrl_word({strobe_pol, ch_pass, drv_en, drv_strong}),
    .ch_delay(ch_delay)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
    localparam int NCH  = 8;
    localparam int HOLD = 12;
    localparam int Q    = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_pick = 1'b0, wide_stat = 1'b0;
    logic scl_line, sda_line;
    logic sda_oe, scl_oe, strobe_pol, drv_en, drv_strong;
    logic [7:0] ch_pass;
    logic [NCH*16-1:0] ch_delay;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_slave #(.NUM_CH(NCH), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .addr_pick(addr_pick), .wide_stat(wide_stat), .sda_oe(sda_oe),
        .scl_oe(scl_oe), .strobe_pol(strobe_pol), .ch_pass(ch_pass),
        .drv_en(drv_en), .drv_strong(drv_strong), .ch_delay(ch_delay)
    );

    int checks = 0, errors = 0;
    int run = 0, last_run = 0, n_holds = 0, cyc = 0;
    logic [10:0] m_ctrl = '0;
    logic [15:0] m_dly [NCH];

    always @(negedge clk) begin
        if (scl_oe) run++;
        else begin
            if (run > 0) begin last_run = run; n_holds++; end
            run = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_vec();
        logic [127:0] v = '0;
        for (int i = 0; i < NCH; i++) v[i*16 +: 16] = m_dly[i];
        return v;
    endfunction

    function automatic logic [15:0] exp_reg(input int idx);
        if (idx == 0) return {1'b0, wide_stat, 3'b000, m_ctrl};
        return m_dly[idx-1];
    endfunction

    function automatic logic [7:0] dev_w(input logic pick);
        return pick ? 8'h84 : 8'h82;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        do @(negedge clk); while (!scl_line);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_up(); tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_up(); tick(Q/2); b = sda_line;
        tick(Q - Q/2); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_up(); tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_up(); tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(~give_ack);
    endtask

    task automatic reg_wr(input logic [7:0] dev, input logic [7:0] sub,
                          input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        wbyte(dev, acks[3]); wbyte(sub, acks[2]);
        wbyte(d[15:8], acks[1]); wbyte(d[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic reg_rd(input logic [7:0] dev, input logic [7:0] sub,
                          output logic [15:0] d, output logic [2:0] acks);
        bus_start();
        wbyte(dev, acks[2]); wbyte(sub, acks[1]);
        bus_start();
        wbyte(dev | 8'h01, acks[0]);
        rbyte(1'b1, d[15:8]); rbyte(1'b0, d[7:0]);
        bus_stop();
    endtask

    initial begin
        logic [3:0] a4;
        logic [2:0] a3;
        logic [15:0] rd;
        logic aa;
        int unsigned seed = $urandom(32'h5eed);
        for (int i = 0; i < NCH; i++) m_dly[i] = '0;
        tick(6); rst = 1'b0; tick(6);

        // R6 reset state
        chk("R6 ctrl", {strobe_pol, ch_pass, drv_en, drv_strong}, 0);
        chk("R6 delay", ch_delay, 0);
        chk("R6 drivers", {sda_oe, scl_oe}, 0);

        // R1 foreign address with pick low
        reg_wr(8'h84, 8'h01, 16'hAAAA, a4);
        chk("R1 foreign addr nak", a4[3], 0);
        chk("R1 no change", ch_delay, exp_vec());

        // R3 / R2 write channel 3
        reg_wr(8'h82, 8'h03, 16'h1234, a4); m_dly[2] = 16'h1234;
        chk("R3 acks", a4, 4'hF);
        chk("R2 ch3 slice", ch_delay[47:32], 16'h1234);
        chk("R5 hold seen", n_holds > 0, 1);
        chk("R5 hold length", last_run, HOLD);
        chk("R11 released after stop", {sda_oe, scl_oe}, 0);

        // R1 pick high
        addr_pick = 1'b1;
        reg_wr(8'h82, 8'h08, 16'h1111, a4);
        chk("R1 low pair nak when high", a4[3], 0);
        reg_wr(8'h84, 8'h08, 16'hBEEF, a4); m_dly[7] = 16'hBEEF;
        chk("R1 high pair acks", a4, 4'hF);
        chk("R2 ch8 slice", ch_delay[127:112], 16'hBEEF);

        // R4 read back
        reg_rd(8'h84, 8'h08, rd, a3);
        chk("R4 read acks", a3, 3'b111);
        chk("R4 read data", rd, 16'hBEEF);
        reg_rd(8'h84, 8'h03, rd, a3);
        chk("R4 read ch3", rd, 16'h1234);

        // R8 control fields
        reg_wr(8'h84, 8'h00, 16'h0406, a4); m_ctrl = 11'h406;
        chk("R8 pol", strobe_pol, 1);
        chk("R8 pass ch1 only", ch_pass, 8'h01);
        chk("R8 drv_en", drv_en, 1);
        chk("R8 drv_strong", drv_strong, 0);
        reg_wr(8'h84, 8'h00, 16'hFFFD, a4); m_ctrl = 11'h7FD;
        chk("R8 all fields", {strobe_pol, ch_pass, drv_en, drv_strong}, 11'h7FD);

        // R7 status bit and masked bits
        wide_stat = 1'b1;
        reg_rd(8'h84, 8'h00, rd, a3);
        chk("R7 ctrl read wide", rd, 16'h47FD);
        wide_stat = 1'b0;
        reg_rd(8'h84, 8'h00, rd, a3);
        chk("R7 ctrl read narrow", rd, 16'h07FD);

        // R9 invalid subaddress
        reg_wr(8'h84, 8'h09, 16'h5555, a4);
        chk("R9 data nak", a4, 4'b1100);
        chk("R9 delay unchanged", ch_delay, exp_vec());
        chk("R9 ctrl unchanged", {strobe_pol, ch_pass, drv_en, drv_strong}, m_ctrl);
        reg_rd(8'h84, 8'h0C, rd, a3);
        chk("R9 read addr nak", a3, 3'b110);

        // R10 partial write
        bus_start();
        wbyte(8'h84, aa); wbyte(8'h05, aa); wbyte(8'h77, aa);
        chk("R10 high byte acked", aa, 1);
        bus_stop();
        chk("R10 unchanged", ch_delay, exp_vec());
        reg_rd(8'h84, 8'h05, rd, a3);
        chk("R10 readback", rd, 16'h0000);
        chk("R11 released", {sda_oe, scl_oe}, 0);

        // random writes over both pairs and all registers
        for (int n = 0; n < 24; n++) begin
            logic [3:0] s;
            logic [15:0] d;
            addr_pick = 1'($urandom);
            s = 4'($urandom % 9);
            d = 16'($urandom);
            reg_wr(dev_w(addr_pick), {4'h0, s}, d, a4);
            if (s == 0) m_ctrl = d[10:0]; else m_dly[s-1] = d;
            chk("R3 random acks", a4, 4'hF);
            chk("R2 random delay", ch_delay, exp_vec());
            chk("R8 random ctrl", {strobe_pol, ch_pass, drv_en, drv_strong}, m_ctrl);
        end
        for (int i = 0; i <= NCH; i++) begin
            wide_stat = 1'($urandom);
            reg_rd(dev_w(addr_pick), 8'(i), rd, a3);
            chk("R4 random readback", rd, exp_reg(i));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule